// File: doc/BRIEF.md
# Burst-of-two SRAM write port

This block is the write side of a synchronous SRAM with separate data-in and data-out paths and a fixed burst of two words. One beat-rate clock drives it. A write is a two-edge transaction. On the first edge the active-low write strobe is taken low, and the first data beat and its lane masks are captured. On the next edge the block captures the pair address, the second data beat and the masks for that beat. It then stores both words at once.

The storage is split into 9-bit lanes. Each lane has its own active-low enable for each beat, so any lane of either word can be left untouched. The address names a word pair. The first beat goes to the even word of the pair and the second beat to the odd word. A registered read-back port lets a bench or a neighbour observe any stored word. The block accepts a new command on the edge right after an address edge, so writes can run back to back with no idle cycle. The asynchronous reset drops a half-finished write and keeps the array contents.

Top module: `sb2_wr_port`

## Requirements
- R1: With no write pending, a low `wr_ni` at a clock edge opens a write, and that same edge captures `d_i` as the first beat and `bw_ni` as its lane masks. Data present on later edges does not replace the first beat.
- R2: With no write pending, a high `wr_ni` at an edge is a deselect. No word changes, whatever `addr_i`, `d_i` and `bw_ni` carry.
- R3: The edge after a command edge is the address edge. It captures `addr_i`, the second beat from `d_i` and its masks from `bw_ni`. `wr_ni` is ignored on that edge.
- R4: The first beat is stored at word address `2*addr_i` (bit 0 = 0) and the second beat at `2*addr_i+1` (bit 0 = 1).
- R5: `bw_ni[k]` high leaves lane k (data bits 9k+8 down to 9k) of that beat's word unchanged. The masks of the two beats are independent.
- R6: A command is accepted on the edge right after an address edge, so a steady stream of writes completes one pair every two cycles.
- R7: Nothing is stored before the address edge. A low `rst_ni` between the command edge and the address edge cancels the pending write. After reset the next edge is a command edge, and the array contents survive reset.
- R8: `rd_data_o` is registered. After an edge it shows the word at `rd_addr_i` as stored before that edge, and it holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the capture pipeline |
| wr_ni | input | 1 | Active-low write command strobe |
| addr_i | input | AW (6) | Word-pair address, captured on the address edge |
| d_i | input | LANES*LW (18) | Data in, one beat per edge |
| bw_ni | input | LANES (2) | Active-low lane enables for the current beat |
| rd_addr_i | input | AW+1 (7) | Word address for read-back |
| rd_data_o | output | LANES*LW (18) | Registered read-back word |

## Verification
Every fault in the pipeline shows up in the array, and the read-back port makes it visible one edge after a read is requested. A phase register that is stuck or skips a step turns a deselect or an ignored strobe into a stray pair write. It can also shift a beat into the wrong word. Either error shows on the next read of the affected pair. A wrong held beat or mask appears as a corrupted lane in the even word. A reset that fails to clear the phase shows as a write to the pair driven during reset.

// File: rtl/sb2_pkg.sv
package sb2_pkg;
  typedef enum logic {PH_CMD = 1'b0, PH_ADDR = 1'b1} phase_e;
endpackage

// File: rtl/sb2_capture.sv
module sb2_capture #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    d_i,
  input  logic [LANES-1:0] bw_ni,
  output logic             busy_o,
  output logic             commit_o,
  output logic [AW-1:0]    pair_o,
  output logic [DW-1:0]    d0_o,
  output logic [DW-1:0]    d1_o,
  output logic [LANES-1:0] we0_o,
  output logic [LANES-1:0] we1_o
);
  import sb2_pkg::*;

  phase_e           phase_q;
  logic [DW-1:0]    d0_q;
  logic [LANES-1:0] m0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
    end else begin
      unique case (phase_q)
        PH_CMD:  if (!wr_ni) phase_q <= PH_ADDR;
        PH_ADDR: phase_q <= PH_CMD; // strobe ignored on address edge
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  // beat one held until the address edge
  always_ff @(posedge clk_i) begin
    if (phase_q == PH_CMD && !wr_ni) begin
      d0_q <= d_i;
      m0_q <= bw_ni;
    end
  end

  assign busy_o   = (phase_q == PH_ADDR);
  assign commit_o = busy_o;
  assign pair_o   = addr_i;
  assign d0_o     = d0_q;
  assign d1_o     = d_i;
  assign we0_o    = {LANES{commit_o}} & ~m0_q;
  assign we1_o    = {LANES{commit_o}} & ~bw_ni;
endmodule

// File: rtl/sb2_lane.sv
module sb2_lane #(
  parameter int AW    = 6,
  parameter int LW    = 9,
  localparam int WA    = AW + 1,
  localparam int DEPTH = 1 << WA
) (
  input  logic          clk_i,
  input  logic          we0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] pair_i,
  input  logic [LW-1:0] d0_i,
  input  logic [LW-1:0] d1_i,
  input  logic [WA-1:0] rd_addr_i,
  output logic [LW-1:0] rd_o
);
  logic [LW-1:0] mem_q [DEPTH];

  // even/odd words of a pair never collide
  always_ff @(posedge clk_i) begin
    if (we0_i) mem_q[{pair_i, 1'b0}] <= d0_i;
    if (we1_i) mem_q[{pair_i, 1'b1}] <= d1_i;
    rd_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/sb2_wr_port.sv
module sb2_wr_port #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    d_i,
  input  logic [LANES-1:0] bw_ni,
  input  logic [AW:0]      rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  logic             busy_w, commit_w;
  logic [AW-1:0]    pair_w;
  logic [DW-1:0]    d0_w, d1_w;
  logic [LANES-1:0] we0_w, we1_w;

  sb2_capture #(.AW(AW), .LANES(LANES), .LW(LW)) u_cap (
    .clk_i, .rst_ni, .wr_ni, .addr_i, .d_i, .bw_ni,
    .busy_o(busy_w), .commit_o(commit_w), .pair_o(pair_w),
    .d0_o(d0_w), .d1_o(d1_w), .we0_o(we0_w), .we1_o(we1_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sb2_lane #(.AW(AW), .LW(LW)) u_lane (
      .clk_i,
      .we0_i(we0_w[l]),
      .we1_i(we1_w[l]),
      .pair_i(pair_w),
      .d0_i(d0_w[l*LW +: LW]),
      .d1_i(d1_w[l*LW +: LW]),
      .rd_addr_i,
      .rd_o(rd_data_o[l*LW +: LW])
    );
  end
endmodule

// File: rtl/sb2_chk.sv
module sb2_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_ni,
  input logic busy_i,
  input logic commit_i
);
  // R1
  cmd_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !wr_ni) |=> busy_i);
  // R2
  deselect_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wr_ni) |=> (!busy_i && !commit_i));
  // R3
  addr_edge_ignores_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !busy_i);
  // R7
  commit_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(!wr_ni));
  // R7
  reset_clears_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_i && !commit_i));
endmodule

bind sb2_wr_port sb2_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ni(wr_ni),
  .busy_i(busy_w), .commit_i(commit_w)
);

// File: tb/sb2_wr_port_test.sv
module sb2_wr_port_test;
  localparam int AW = 6, LANES = 2, LW = 9, DW = LANES * LW, WORDS = 1 << (AW + 1);

  logic clk = 1'b0, rst_ni = 1'b0, wr_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [LANES-1:0] bw_n = '1;
  logic [AW:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] model [WORDS];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sb2_wr_port #(.AW(AW), .LANES(LANES), .LW(LW)) uut (
    .clk_i(clk), .rst_ni, .wr_ni, .addr_i(addr), .d_i(d), .bw_ni(bw_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LANES-1:0] m);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (!m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge with wr_ni high
  task automatic do_write(int pair, logic [DW-1:0] d0, logic [LANES-1:0] m0,
                          logic [DW-1:0] d1, logic [LANES-1:0] m1, bit strobe_on_addr);
    wr_ni = 1'b0; d = d0; bw_n = m0; addr = ~pair[AW-1:0];
    @(posedge clk); @(negedge clk);
    wr_ni = strobe_on_addr ? 1'b0 : 1'b1;
    addr = pair[AW-1:0]; d = d1; bw_n = m1;
    @(posedge clk); @(negedge clk);
    wr_ni = 1'b1; d = ~d1; bw_n = '0;
    model[2*pair]   = merge(model[2*pair], d0, m0);
    model[2*pair+1] = merge(model[2*pair+1], d1, m1);
  endtask

  task automatic read_check(string req, int a);
    rd_addr = a[AW:0];
    @(posedge clk); @(negedge clk);
    check(req, rd_data, model[a]);
  endtask

  task automatic t_fill;
    for (int p = 0; p < WORDS / 2; p++)
      do_write(p, DW'(p * 1031 + 7), '0, DW'(p * 977 + 3), '0, 1'b0);
    for (int a = 0; a < WORDS; a += 13) read_check("R4 fill placement", a);
    read_check("R4 even word", 2 * 21);
    read_check("R4 odd word", 2 * 21 + 1);
  endtask

  task automatic t_masks;
    do_write(5, 18'h3_1111, 2'b01, 18'h2_2222, 2'b10, 1'b0);
    read_check("R5 beat0 lane0 masked", 10);
    read_check("R5 beat1 lane1 masked", 11);
    do_write(6, 18'h0_abcd, 2'b11, 18'h1_5a5a, 2'b00, 1'b0);
    read_check("R5 beat0 all masked", 12);
    read_check("R1 beat0 not replaced by beat1", 13);
    do_write(7, 18'h2_4681, 2'b10, 18'h0_0000, 2'b11, 1'b0);
    read_check("R1 beat0 captured at command edge", 14);
    read_check("R5 beat1 all masked", 15);
  endtask

  task automatic t_deselect;
    for (int i = 0; i < 6; i++) begin
      wr_ni = 1'b1; addr = AW'(30 + i); d = 18'h3_ffff - DW'(i); bw_n = '0;
      @(posedge clk); @(negedge clk);
    end
    for (int i = 0; i < 6; i++) read_check("R2 deselect stores nothing", 60 + 2 * i);
  endtask

  task automatic t_ignored_strobe;
    do_write(40, 18'h1_0f0f, 2'b00, 18'h2_f0f0, 2'b00, 1'b1);
    // if the address-edge strobe were taken, this cycle would store into pair 41
    wr_ni = 1'b1; addr = AW'(41); d = 18'h3_3333; bw_n = '0;
    @(posedge clk); @(negedge clk);
    read_check("R3 second beat stored", 81);
    read_check("R3 strobe on address edge ignored (even)", 82);
    read_check("R3 strobe on address edge ignored (odd)", 83);
  endtask

  task automatic t_back_to_back;
    for (int p = 50; p < 54; p++)
      do_write(p, DW'(p * 311), 2'b00, DW'(p * 517), 2'b00, 1'b0);
    for (int p = 50; p < 54; p++) begin
      read_check("R6 back-to-back even", 2 * p);
      read_check("R6 back-to-back odd", 2 * p + 1);
    end
  endtask

  task automatic t_reset_abort;
    wr_ni = 1'b0; d = 18'h1_2345; bw_n = '0; addr = AW'(60);
    @(posedge clk); @(negedge clk);
    rst_ni = 1'b0; wr_ni = 1'b1; addr = AW'(60); d = 18'h2_5432; bw_n = '0;
    @(posedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    read_check("R7 aborted write even kept", 120);
    read_check("R7 aborted write odd kept", 121);
    read_check("R7 contents survive reset", 2 * 21);
    do_write(61, 18'h0_7777, 2'b00, 18'h0_8888, 2'b00, 1'b0);
    read_check("R7 first edge after reset is command", 122);
    read_check("R7 first edge after reset is command", 123);
  endtask

  task automatic t_readback;
    logic [DW-1:0] held;
    rd_addr = 7'd10;
    @(posedge clk); @(negedge clk);
    check("R8 registered read", rd_data, model[10]);
    held = rd_data;
    rd_addr = 7'd11;
    #1;
    check("R8 output holds until edge", rd_data, held);
    @(posedge clk); @(negedge clk);
    check("R8 new address after edge", rd_data, model[11]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_fill();
    t_masks();
    t_deselect();
    t_ignored_strobe();
    t_back_to_back();
    t_reset_abort();
    t_readback();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule